// File: doc/BRIEF.md
# Page-Latched Write Buffer with Address Counter

This block sits behind a serial-memory protocol front end and owns everything between a decoded request and the storage cells. It keeps the current-address counter, and it collects write bytes in a one-page latch that carries a per-byte valid mask. It writes the latched page into a register-based array when a commit arrives, and it then holds a busy flag for a programmable number of cycles to model the programming time. Reads come straight from the array at the counter and advance it across the whole 15-bit space. Writes advance only the index inside the 64-byte page.

Requests arrive on a valid/ready channel. A request transfers on a rising clock edge when `req_valid` and `req_ready` are both high. `req_ready` is low for as long as a programming cycle runs. While it is low, the sender must hold `req_valid`, `req_op`, `req_addr` and `req_data` steady. Read data leaves on `rd_valid`/`rd_data` for one cycle, with no back-pressure, so the front end must take it on that cycle. `wp` and `busy` are plain level pins.

The array holds 2^MEM_AW bytes. An address selects the array byte given by its low MEM_AW bits, so higher addresses alias onto it, while the counter itself always spans the full 15 bits.

Top module: `ep_page_store`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, `rd_valid` is 0, the address counter is 0 and every array byte is 0x00.
- R2: A write request (`req_op`=1) stores `req_data` in the latch at index counter[5:0] and marks that byte valid. It then advances counter[5:0] by one while counter[14:6] stays unchanged.
- R3: When a write moves the page index past 63, the index returns to 0 in the same page. A later byte at an index already filled replaces the latched value.
- R4: A commit (`req_op`=3) with `wp` low writes only the valid latched bytes into their page of the array, and the other bytes of that page keep their contents. The latch is emptied and the counter is left as it was, so after a write that ended on index 63 the counter points at index 0 of the same page.
- R5: A read (`req_op`=2) returns the array byte at the counter on `rd_data`, with `rd_valid` high on the cycle after the request is accepted. The full 15-bit counter then increments, rolling from 0x7FFF to 0x0000. The array byte used is selected by the low MEM_AW address bits.
- R6: An accepted commit with at least one valid byte raises `busy` for exactly WC_CYCLES cycles. `req_ready` equals not `busy`, and no request is accepted while `busy` is high.
- R7: `wp` is sampled at the edge that accepts a commit. If it is high there, the array is unchanged, but the latch is still emptied and `busy` still runs. Reads are unaffected by `wp`.
- R8: A commit with an empty latch is ignored: `busy` stays 0 and the array is unchanged.
- R9: A load-address request (`req_op`=0) sets the counter to `req_addr`. Load-address and read requests both discard any latched bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when valid is also high |
| req_op | input | 2 | 0 load address, 1 write byte, 2 read byte, 3 commit |
| req_addr | input | 15 | Address for load-address |
| req_data | input | 8 | Byte for write |
| wp | input | 1 | Write protect, sampled at commit |
| rd_valid | output | 1 | Read byte present (one cycle) |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Programming cycle in progress |

## Verification
Two kinds of event can coincide. A single write at page index 63 both latches its byte and wraps the index. Continuing past the wrap puts a byte into a slot that is already filled. The bench provokes this by streaming 65 bytes into one page and by crossing index 63 with a few bytes. It judges the result by reading back index 0 and the current address after commit. The second coincidence is a request held valid through a programming cycle, which must be taken on the first edge after `busy` falls. The bench checks that `rd_valid` stays low throughout `busy` and that the held read then returns the byte at the page-wrapped counter.

// File: rtl/ep_page_pkg.sv
package ep_page_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_COMMIT = 2'd3
  } ep_op_e;
endpackage

// File: rtl/ep_addr_counter.sv
module ep_addr_counter #(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step_page,
  input  logic          step_full,
  output logic [AW-1:0] cnt
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_addr;
    else if (step_page)
      cnt_q <= {cnt_q[AW-1:PW], cnt_q[PW-1:0] + 1'b1};
    else if (step_full)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R2: page-local stepping never touches the page number
  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !load) |=> (cnt[AW-1:PW] == $past(cnt[AW-1:PW])));
endmodule

// File: rtl/ep_page_latch.sv
module ep_page_latch #(
  parameter int PW   = 6,
  parameter int DW   = 8,
  parameter int TAGW = 3,
  localparam int PB  = 1 << PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_idx,
  input  logic [TAGW-1:0] wr_tag,
  input  logic [DW-1:0]   wr_data,
  output logic [PB-1:0]   mask,
  output logic [TAGW-1:0] tag,
  output logic [PB*DW-1:0] data_flat
);
  logic [DW-1:0]   buf_q [PB];
  logic [PB-1:0]   mask_q;
  logic [TAGW-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      tag_q  <= '0;
      for (int i = 0; i < PB; i++) buf_q[i] <= '0;
    end else if (clear) begin
      mask_q <= '0;
    end else if (wr_en) begin
      buf_q[wr_idx]  <= wr_data;
      mask_q[wr_idx] <= 1'b1;
      tag_q          <= wr_tag;
    end
  end

  for (genvar g = 0; g < PB; g++) begin : g_flat
    assign data_flat[g*DW +: DW] = buf_q[g];
  end

  assign mask = mask_q;
  assign tag  = tag_q;

  // R4/R9: a clear leaves no byte marked valid
  p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));
  // R2: a latched byte is marked valid at its index
  p_mark_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> mask[$past(wr_idx)]);
endmodule

// File: rtl/ep_wc_timer.sv
module ep_wc_timer #(
  parameter int WC_CYCLES = 20,
  localparam int TW = $clog2(WC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (start)
      left_q <= TW'(WC_CYCLES);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  // R6: a cycle is only started from idle and is visible on the next cycle
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/ep_mem_array.sv
module ep_mem_array #(
  parameter int MAW = 9,
  parameter int PW  = 6,
  parameter int DW  = 8,
  localparam int PB    = 1 << PW,
  localparam int DEPTH = 1 << MAW,
  localparam int TAGW  = MAW - PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  input  logic [TAGW-1:0]  commit_tag,
  input  logic [PB-1:0]    commit_mask,
  input  logic [PB*DW-1:0] commit_data,
  input  logic             rd_en,
  input  logic [MAW-1:0]   rd_addr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  logic [DW-1:0] cells [DEPTH];

  function automatic logic [MAW-1:0] slot(input logic [TAGW-1:0] t, input int i);
    logic [PW-1:0] ix;
    ix = i[PW-1:0];
    return {t, ix};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int j = 0; j < DEPTH; j++) cells[j] <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= cells[rd_addr];
      if (commit_en) begin
        for (int i = 0; i < PB; i++)
          if (commit_mask[i]) cells[slot(commit_tag, i)] <= commit_data[i*DW +: DW];
      end
    end
  end

  // R5: read data appears only for a read issued the cycle before
  p_rd_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
endmodule

// File: rtl/ep_page_store.sv
module ep_page_store
  import ep_page_pkg::*;
#(
  parameter int AW        = 15,
  parameter int PW        = 6,
  parameter int DW        = 8,
  parameter int MEM_AW    = 9,
  parameter int WC_CYCLES = 20,
  localparam int PB   = 1 << PW,
  localparam int TAGW = MEM_AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wp,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic          fire, is_load, is_write, is_read, is_commit, commit_go;
  logic [AW-1:0] cnt;
  logic [PB-1:0] mask;
  logic [TAGW-1:0] tag;
  logic [PB*DW-1:0] page_data;

  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;
  assign is_load   = fire && (req_op == OP_LOAD);
  assign is_write  = fire && (req_op == OP_WRITE);
  assign is_read   = fire && (req_op == OP_READ);
  assign is_commit = fire && (req_op == OP_COMMIT);
  assign commit_go = is_commit && (mask != '0);

  ep_addr_counter #(.AW(AW), .PW(PW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(is_load), .load_addr(req_addr),
    .step_page(is_write), .step_full(is_read), .cnt(cnt)
  );

  ep_page_latch #(.PW(PW), .DW(DW), .TAGW(TAGW)) u_latch (
    .clk(clk), .rst_n(rst_n), .clear(is_load || is_read || commit_go),
    .wr_en(is_write), .wr_idx(cnt[PW-1:0]), .wr_tag(cnt[MEM_AW-1:PW]),
    .wr_data(req_data), .mask(mask), .tag(tag), .data_flat(page_data)
  );

  ep_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_go), .busy(busy)
  );

  ep_mem_array #(.MAW(MEM_AW), .PW(PW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .commit_en(commit_go && !wp),
    .commit_tag(tag), .commit_mask(mask), .commit_data(page_data),
    .rd_en(is_read), .rd_addr(cnt[MEM_AW-1:0]),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R5: an accepted read moves the full counter by one, wrapping at the top
  p_full_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> (cnt == $past(cnt) + 1'b1));
  p_rd_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |=> rd_valid);
  // R8: an empty commit starts nothing
  p_empty_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_commit && (mask == '0)) |=> !busy);
  // R4: a commit leaves the counter where the writes left it
  p_commit_keeps_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_commit |=> $stable(cnt));
endmodule

// File: tb/tb_ep_page_store.sv
`timescale 1ns/1ps
module tb_ep_page_store;
  localparam int WC = 20;
  localparam logic [1:0] LD = 2'd0, WR = 2'd1, RD = 2'd2, CM = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wp = 1'b0;
  logic [1:0] req_op = '0;
  logic [14:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, rd_valid, busy;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ep_page_store #(.WC_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .wp(wp),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  // vector: {op, addr, data, check, expected}
  localparam int NV = 14;
  localparam logic [33:0] VEC [NV] = '{
    {LD, 15'h0040, 8'h00, 1'b0, 8'h00},
    {WR, 15'h0000, 8'hAA, 1'b0, 8'h00},
    {WR, 15'h0000, 8'hBB, 1'b0, 8'h00},
    {CM, 15'h0000, 8'h00, 1'b0, 8'h00},
    {LD, 15'h0040, 8'h00, 1'b0, 8'h00},
    {RD, 15'h0000, 8'h00, 1'b1, 8'hAA},
    {RD, 15'h0000, 8'h00, 1'b1, 8'hBB},
    {RD, 15'h0000, 8'h00, 1'b1, 8'h00},
    {WR, 15'h0000, 8'h11, 1'b0, 8'h00},
    {CM, 15'h0000, 8'h00, 1'b0, 8'h00},
    {LD, 15'h0040, 8'h00, 1'b0, 8'h00},
    {RD, 15'h0000, 8'h00, 1'b1, 8'hAA},
    {RD, 15'h0000, 8'h00, 1'b1, 8'hBB},
    {RD, 15'h0000, 8'h00, 1'b1, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [14:0] a, input logic [7:0] d);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic commit();
    do_req(CM, '0, '0);
    wait_idle();
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    do_req(RD, '0, '0);
    chk({tag, " rd_valid"}, rd_valid, 1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 rd_valid", rd_valid, 0);
    rd(8'h00, "R1 counter zero, array clear");

    // table: R2 write, R4 mask-limited commit, R5 reads
    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v][33:32], VEC[v][31:17], VEC[v][16:9]);
      if (VEC[v][33:32] == CM) wait_idle();
      if (VEC[v][8]) begin
        chk($sformatf("R4/R5 vec%0d rd_valid", v), rd_valid, 1);
        chk($sformatf("R4/R5 vec%0d rd_data", v), rd_data, VEC[v][7:0]);
      end
    end

    // R3 page wrap across index 63, R4 untouched byte keeps value
    do_req(LD, 15'h0083, 0); do_req(WR, 0, 8'h66); commit();
    do_req(LD, 15'h00BE, 0);
    do_req(WR, 0, 8'h11); do_req(WR, 0, 8'h22); do_req(WR, 0, 8'h33);
    do_req(WR, 0, 8'h44); do_req(WR, 0, 8'h55);
    commit();
    rd(8'h66, "R4 counter page-wrapped, idx3 kept");
    do_req(LD, 15'h0080, 0);
    rd(8'h33, "R3 wrapped idx0"); rd(8'h44, "R3 idx1"); rd(8'h55, "R3 idx2");
    do_req(LD, 15'h00BE, 0);
    rd(8'h11, "R2 idx62"); rd(8'h22, "R2 idx63");
    rd(8'h00, "R5 read crosses page");

    // R3 overwrite with 65 bytes, R6 busy length and held request
    do_req(LD, 15'h0100, 0);
    for (int i = 0; i < 65; i++) do_req(WR, 0, 8'(i));
    do_req(CM, 0, 0);
    chk("R6 busy after commit", busy, 1);
    req_op = RD; req_valid = 1'b1;
    n = 0;
    while (busy) begin
      n++;
      if (req_ready || rd_valid) chk("R6 nothing accepted while busy", 1, 0);
      @(negedge clk);
    end
    chk("R6 busy cycles", n, WC);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 held read taken", rd_valid, 1);
    chk("R3 held read at idx1", rd_data, 8'h01);
    do_req(LD, 15'h0100, 0);
    rd(8'd64, "R3 idx0 overwritten");
    do_req(LD, 15'h013F, 0);
    rd(8'd63, "R3 idx63");

    // R5 full-space rollover and array aliasing
    do_req(LD, 15'h7FFF, 0); do_req(WR, 0, 8'h5A); commit();
    do_req(LD, 15'h0000, 0); do_req(WR, 0, 8'hA5); commit();
    do_req(LD, 15'h7FFF, 0);
    rd(8'h5A, "R5 top address"); rd(8'hA5, "R5 rolled to 0"); rd(8'h00, "R5 addr 1");

    // R9 load discards latch, R8 empty commit ignored
    do_req(LD, 15'h0140, 0); do_req(WR, 0, 8'h77);
    do_req(LD, 15'h0180, 0);
    do_req(CM, 0, 0);
    chk("R8 empty commit no busy", busy, 0);
    do_req(LD, 15'h0140, 0);
    rd(8'h00, "R9 discarded byte not written");
    do_req(LD, 15'h0150, 0); do_req(WR, 0, 8'h78);
    do_req(RD, 0, 0);
    do_req(CM, 0, 0);
    chk("R9 read discards latch", busy, 0);

    // R7 write protect
    wp = 1'b1;
    do_req(LD, 15'h0180, 0); do_req(WR, 0, 8'h12);
    do_req(CM, 0, 0);
    chk("R7 busy runs under wp", busy, 1);
    wait_idle();
    wp = 1'b1;
    do_req(LD, 15'h0181, 0); do_req(WR, 0, 8'h34);
    wp = 1'b0; do_req(CM, 0, 0); wp = 1'b1; wait_idle();
    wp = 1'b0;
    do_req(LD, 15'h0182, 0); do_req(WR, 0, 8'h56);
    wp = 1'b1; do_req(CM, 0, 0); wp = 1'b0; wait_idle();
    wp = 1'b1;
    do_req(LD, 15'h0180, 0);
    rd(8'h00, "R7 protected commit"); rd(8'h34, "R7 wp low at commit");
    rd(8'h00, "R7 wp high at commit");
    wp = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule